// File: doc/BRIEF.md
# Scrolling Tile-Map Line Renderer

This block draws a 320x240 tiled background onto a 640x480 raster. The raster is described to it by a few inputs: a pulse at the start of horizontal blanking, the number of the scan line about to be shown, an active-video flag and the active pixel column. The tile plane is 64x64 tiles of 8x8 pixels, which gives a 512x512 pixel virtual surface. Every pixel is an 8-bit palette index.

On each even scan line the block fills a whole-line buffer of 320 logical pixels. For each tile it first reads a tile number from an external synchronous map RAM and waits out that RAM's read latency. It then requests the matching 8-byte tile row from video memory over a request/ready port. Finally it writes the wanted bytes into the buffer, one per cycle.

During active video the buffer is read once for every pair of columns, so each logical pixel covers two raster pixels. The buffer is left untouched on odd scan lines, so each row is shown twice. Scrolling on both axes has pixel granularity and wraps at 512 pixels. When the horizontal scroll is not a multiple of 8, one extra tile is fetched for the line.

Top module: `tile_line_renderer`

## Requirements
- R1: While reset is asserted and after its release, before any line is rendered, `pix_o` is 0 and `mem_req_o` is 0.
- R2: A video-memory request addresses byte `tile*64 + fy*8`, so its low 3 bits are 0 and bits [5:3] hold the fine Y row `fy`. In the returned 64-bit word, byte k (bits 8k+7..8k) is tile column k.
- R3: While `active_i` is high, `pix_o` one cycle after an even column h shows logical pixel h/2. On the following odd column it holds that value, so every logical pixel spans two raster columns.
- R4: A blank-start pulse with an even `next_line_i` starts a fill for logical row `next_line_i/2`. A pulse with an odd `next_line_i` issues no memory requests and leaves the buffer unchanged.
- R5: The vertical position used for a fill is (`next_line_i/2` + `scroll_y_i`) mod 512. Its bits [8:3] select the map row and bits [2:0] select the tile row.
- R6: Logical pixel x of a line comes from plane column (x + `scroll_x_i`) mod 512. A line makes 40 video-memory reads when `scroll_x_i` mod 8 is 0, and 41 reads otherwise.
- R7: The map address is `map_row*64 + map_col`. It is held for MAP_LAT+1 cycles, and the tile number is taken from `map_data_i` in the last of those cycles.
- R8: Once `mem_req_o` is raised it stays high with a stable `mem_addr_o` until a cycle in which `mem_ready_i` is high. Read data is taken in that cycle.
- R9: When `active_i` is low, `pix_o` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | One-cycle pulse at the start of horizontal blanking |
| next_line_i | input | 10 | Scan line (0..479) to be displayed after this blanking |
| scroll_x_i | input | 9 | Horizontal scroll in plane pixels, sampled at a starting pulse |
| scroll_y_i | input | 9 | Vertical scroll in plane pixels, sampled at a starting pulse |
| active_i | input | 1 | Active video flag |
| hcount_i | input | 10 | Raster column 0..639 during active video |
| pix_o | output | 8 | Palette index, registered |
| map_addr_o | output | 12 | Map RAM read address {row, column} |
| map_data_i | input | 10 | Map RAM read data (tile number), MAP_LAT cycles after the address |
| mem_req_o | output | 1 | Video memory read request |
| mem_addr_o | output | 16 | Video memory byte address of a tile row |
| mem_ready_i | input | 1 | Video memory ready; data is valid in the same cycle |
| mem_data_i | input | 64 | Tile row, byte k = column k |

## Verification
Lines are rendered from directed cases and from random scroll values and even line numbers. Every raster pixel is compared with a plane computed by the bench from hash-filled map and tile contents. The directed cases cover:
- zero scroll, which checks plain addressing;
- a fine X offset, which checks the first partial tile and the 41st fetch;
- an aligned coarse offset, which checks the 40-fetch case;
- scroll near 511 on both axes, which checks wraparound at the plane edge.

An odd line pulse with different scroll values must leave the earlier row on screen and make no requests, which separates row reuse from refetching. The map RAM model has a two-cycle latency and memory ready stalls at random, so taking map data a cycle early or dropping a handshake shows up as wrong tiles.

// File: rtl/tlr_pkg.sv
package tlr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAP,
    ST_REQ,
    ST_PUT
  } fetch_st_t;
endpackage

// File: rtl/tlr_rst_sync.sv
module tlr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/tlr_fetch.sv
module tlr_fetch #(
  parameter int TILE_PX   = 8,
  parameter int MAP_TILES = 64,
  parameter int LINE_PIX  = 320,
  parameter int PIX_W     = 8,
  parameter int IDX_W     = 10,
  parameter int MAP_LAT   = 2,
  localparam int FINE_W   = $clog2(TILE_PX),
  localparam int MCOL_W   = $clog2(MAP_TILES),
  localparam int COORD_W  = FINE_W + MCOL_W,
  localparam int MAP_AW   = 2 * MCOL_W,
  localparam int MEM_AW   = IDX_W + 2 * FINE_W,
  localparam int WORD_W   = TILE_PX * PIX_W,
  localparam int PTR_W    = $clog2(LINE_PIX),
  localparam int CNT_W    = $clog2(MAP_LAT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [COORD_W-1:0] scroll_x_i,
  input  logic [COORD_W-1:0] scroll_y_i,
  output logic [MAP_AW-1:0]  map_addr_o,
  input  logic [IDX_W-1:0]   map_data_i,
  output logic               mem_req_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  input  logic               mem_ready_i,
  input  logic [WORD_W-1:0]  mem_data_i,
  output logic               wr_en_o,
  output logic [PTR_W-1:0]   wr_addr_o,
  output logic [PIX_W-1:0]   wr_data_o,
  output logic               map_phase_o
);
  import tlr_pkg::*;

  fetch_st_t          st_q, st_d;
  logic [MCOL_W-1:0]  row_q, row_d, col_q, col_d;
  logic [FINE_W-1:0]  fy_q, fy_d, sel_q, sel_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [WORD_W-1:0]  word_q;
  logic               word_en;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [COORD_W-1:0] vy;

  // vertical plane position wraps by truncation to COORD_W bits
  assign vy = row_i + scroll_y_i;

  always_comb begin
    st_d    = st_q;
    row_d   = row_q;
    col_d   = col_q;
    fy_d    = fy_q;
    sel_d   = sel_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    cnt_d   = cnt_q;
    word_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          row_d = vy[COORD_W-1:FINE_W];
          fy_d  = vy[FINE_W-1:0];
          col_d = scroll_x_i[COORD_W-1:FINE_W];
          sel_d = scroll_x_i[FINE_W-1:0];
          ptr_d = '0;
          cnt_d = '0;
          st_d  = ST_MAP;
        end
      end
      ST_MAP: begin
        // address held while the map RAM latency runs out
        if (cnt_q == CNT_W'(MAP_LAT)) begin
          idx_d = map_data_i;
          st_d  = ST_REQ;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REQ: begin
        if (mem_ready_i) begin
          word_en = 1'b1;
          st_d    = ST_PUT;
        end
      end
      ST_PUT: begin
        ptr_d = ptr_q + 1'b1;
        if (ptr_q == PTR_W'(LINE_PIX - 1)) begin
          st_d = ST_IDLE;
        end else if (sel_q == FINE_W'(TILE_PX - 1)) begin
          sel_d = '0;
          col_d = col_q + 1'b1;
          cnt_d = '0;
          st_d  = ST_MAP;
        end else begin
          sel_d = sel_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
      fy_q  <= '0;
      sel_q <= '0;
      idx_q <= '0;
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      row_q <= row_d;
      col_q <= col_d;
      fy_q  <= fy_d;
      sel_q <= sel_d;
      idx_q <= idx_d;
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= mem_data_i;
  end

  assign map_addr_o  = {row_q, col_q};
  assign map_phase_o = (st_q == ST_MAP);
  assign mem_req_o   = (st_q == ST_REQ);
  assign mem_addr_o  = {idx_q, fy_q, {FINE_W{1'b0}}};
  assign wr_en_o     = (st_q == ST_PUT);
  assign wr_addr_o   = ptr_q;

  always_comb wr_data_o = word_q[int'(sel_q) * PIX_W +: PIX_W];
endmodule

// File: rtl/tlr_line_buf.sv
module tlr_line_buf #(
  parameter int DEPTH  = 320,
  parameter int PIX_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int HC_W  = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_addr_i,
  input  logic [PIX_W-1:0] wr_data_i,
  input  logic             active_i,
  input  logic [HC_W-1:0]  hcount_i,
  output logic [PIX_W-1:0] pix_o
);
  logic [PIX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_addr;
  logic             rd_en;
  logic [PIX_W-1:0] pix_d;

  assign rd_addr = hcount_i[HC_W-1:1];
  // one buffer read per pair of raster columns; odd columns hold
  assign rd_en   = active_i && !hcount_i[0];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_comb begin
    pix_d = pix_o;
    if (!active_i) pix_d = '0;
    else if (rd_en) pix_d = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_o <= '0;
    else        pix_o <= pix_d;
  end
endmodule

// File: rtl/tile_line_renderer.sv
module tile_line_renderer #(
  parameter int TILE_PX   = 8,
  parameter int MAP_TILES = 64,
  parameter int LINE_PIX  = 320,
  parameter int PIX_W     = 8,
  parameter int IDX_W     = 10,
  parameter int MAP_LAT   = 2,
  localparam int FINE_W   = $clog2(TILE_PX),
  localparam int COORD_W  = FINE_W + $clog2(MAP_TILES),
  localparam int LINE_W   = COORD_W + 1,
  localparam int MAP_AW   = 2 * $clog2(MAP_TILES),
  localparam int MEM_AW   = IDX_W + 2 * FINE_W,
  localparam int WORD_W   = TILE_PX * PIX_W,
  localparam int PTR_W    = $clog2(LINE_PIX),
  localparam int HC_W     = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start_i,
  input  logic [LINE_W-1:0]  next_line_i,
  input  logic [COORD_W-1:0] scroll_x_i,
  input  logic [COORD_W-1:0] scroll_y_i,
  input  logic               active_i,
  input  logic [HC_W-1:0]    hcount_i,
  output logic [PIX_W-1:0]   pix_o,
  output logic [MAP_AW-1:0]  map_addr_o,
  input  logic [IDX_W-1:0]   map_data_i,
  output logic               mem_req_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  input  logic               mem_ready_i,
  input  logic [WORD_W-1:0]  mem_data_i
);
  logic             rst_sn;
  logic             fill_start;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic [PIX_W-1:0] wr_data;
  logic             map_phase;

  // odd scan lines reuse the row filled for the even line before them
  assign fill_start = line_start_i && !next_line_i[0];

  tlr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  tlr_fetch #(
    .TILE_PX   (TILE_PX),
    .MAP_TILES (MAP_TILES),
    .LINE_PIX  (LINE_PIX),
    .PIX_W     (PIX_W),
    .IDX_W     (IDX_W),
    .MAP_LAT   (MAP_LAT)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_sn),
    .start_i     (fill_start),
    .row_i       (next_line_i[LINE_W-1:1]),
    .scroll_x_i  (scroll_x_i),
    .scroll_y_i  (scroll_y_i),
    .map_addr_o  (map_addr_o),
    .map_data_i  (map_data_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_data_i  (mem_data_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .map_phase_o (map_phase)
  );

  tlr_line_buf #(
    .DEPTH (LINE_PIX),
    .PIX_W (PIX_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .active_i  (active_i),
    .hcount_i  (hcount_i),
    .pix_o     (pix_o)
  );
endmodule

// File: rtl/tlr_checker.sv
module tlr_checker #(
  parameter int LINE_PIX = 320,
  parameter int PIX_W    = 8,
  parameter int MAP_AW   = 12,
  parameter int MEM_AW   = 16,
  parameter int PTR_W    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active_i,
  input logic [PIX_W-1:0]  pix_o,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [MAP_AW-1:0] map_addr_o,
  input logic              map_phase,
  input logic              wr_en,
  input logic [PTR_W-1:0]  wr_addr
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o))); // R8

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[2:0] == 3'd0)); // R2

  AST_MAP_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (map_phase && $past(map_phase)) |-> $stable(map_addr_o)); // R7

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (pix_o == '0)); // R9

  AST_WRITE_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < LINE_PIX)); // R6

  AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, mem_req_o, map_phase})); // R7
endmodule

bind tile_line_renderer tlr_checker #(
  .LINE_PIX (LINE_PIX),
  .PIX_W    (PIX_W),
  .MAP_AW   (MAP_AW),
  .MEM_AW   (MEM_AW),
  .PTR_W    (PTR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sn),
  .active_i    (active_i),
  .pix_o       (pix_o),
  .mem_req_o   (mem_req_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .map_addr_o  (map_addr_o),
  .map_phase   (map_phase),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr)
);

// File: tb/tile_line_renderer_bench.sv
module tile_line_renderer_bench;
  logic        clk;
  logic        rst_n;
  logic        line_start;
  logic [9:0]  next_line;
  logic [8:0]  scroll_x, scroll_y;
  logic        active;
  logic [9:0]  hcount;
  logic [7:0]  pix;
  logic [11:0] map_addr;
  logic [9:0]  map_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ready;
  logic [63:0] mem_data;

  int checks = 0;
  int errors = 0;
  int hs_count = 0;
  int addr_err = 0;
  int exp_fy = 0;
  int cycles = 0;
  logic [11:0] map_a_q;

  tile_line_renderer u_tile_line_renderer (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .next_line_i(next_line),
    .scroll_x_i(scroll_x), .scroll_y_i(scroll_y), .active_i(active), .hcount_i(hcount),
    .pix_o(pix), .map_addr_o(map_addr), .map_data_i(map_data), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ready_i(mem_ready), .mem_data_i(mem_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int map_f(int a);
    return (((a * 37) + 5) ^ (a >> 3)) & 1023;
  endfunction

  function automatic int tile_byte(int t, int r, int c);
    return (t * 13 + r * 29 + c * 7 + (t >> 2)) & 255;
  endfunction

  function automatic int exp_pix(int x, int line, int sx, int sy);
    int vx, vy, t;
    vx = (x + sx) % 512;
    vy = (line / 2 + sy) % 512;
    t  = map_f((vy / 8) * 64 + vx / 8);
    return tile_byte(t, vy % 8, vx % 8);
  endfunction

  // map RAM model: registered address, registered data (two-cycle latency)
  always @(posedge clk) begin
    map_a_q  <= map_addr;
    map_data <= 10'(map_f(int'(map_a_q)));
  end

  always_comb begin
    for (int k = 0; k < 8; k++)
      mem_data[8*k +: 8] = 8'(tile_byte(int'(mem_addr[15:6]), int'(mem_addr[5:3]), k));
  end

  always @(negedge clk) mem_ready <= (($urandom % 2) == 0);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req && mem_ready) begin
      hs_count <= hs_count + 1;
      if (mem_addr[2:0] != 3'd0 || int'(mem_addr[5:3]) != exp_fy) addr_err <= addr_err + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic render(int line, int sx, int sy, string req);
    int h0, e0;
    @(negedge clk);
    exp_fy     = ((line / 2 + sy) % 512) % 8;
    h0         = hs_count;
    e0         = addr_err;
    line_start = 1'b1;
    next_line  = 10'(line);
    scroll_x   = 9'(sx);
    scroll_y   = 9'(sy);
    @(negedge clk);
    line_start = 1'b0;
    repeat (1500) @(negedge clk);
    if (line % 2 == 0) begin
      chk(hs_count - h0 == ((sx % 8 == 0) ? 40 : 41), "R6", "read count",
          hs_count - h0, (sx % 8 == 0) ? 40 : 41);
      chk(addr_err == e0, "R2", "request address form", addr_err - e0, 0);
    end else begin
      chk(hs_count == h0, "R4", "odd line requests", hs_count - h0, 0);
    end
  endtask

  // scan a full raster line and compare every column against the plane
  task automatic scan(int line, int sx, int sy, string req);
    int bad, first_h, first_a, first_e;
    bad = 0; first_h = -1; first_a = 0; first_e = 0;
    for (int h = 0; h <= 640; h++) begin
      @(negedge clk);
      if (h > 0) begin
        if (int'(pix) != exp_pix((h - 1) / 2, line, sx, sy)) begin
          if (bad == 0) begin
            first_h = h - 1; first_a = int'(pix); first_e = exp_pix((h - 1) / 2, line, sx, sy);
          end
          bad++;
        end
      end
      if (h < 640) begin
        active = 1'b1;
        hcount = 10'(h);
      end else begin
        active = 1'b0;
        hcount = '0;
      end
    end
    if (bad != 0) $display("  first mismatch at column %0d", first_h);
    chk(bad == 0, req, "line pixels (R3 doubling)", first_a, first_e);
  endtask

  initial begin
    void'($urandom(32'd20251));
    rst_n = 1'b0; line_start = 1'b0; next_line = '0;
    scroll_x = '0; scroll_y = '0; active = 1'b0; hcount = '0;
    repeat (3) @(negedge clk);
    chk(pix == 8'd0 && mem_req == 1'b0, "R1", "reset outputs", int'(pix), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pix == 8'd0 && mem_req == 1'b0, "R1", "after reset outputs", int'(mem_req), 0);

    render(0, 0, 0, "R2");        scan(0, 0, 0, "R2");
    render(2, 5, 0, "R6");        scan(2, 5, 0, "R6");
    render(10, 16, 3, "R5");      scan(10, 16, 3, "R5");
    render(478, 511, 509, "R5");  scan(478, 511, 509, "R5 R6 wrap");
    render(100, 250, 0, "R7");    scan(100, 250, 0, "R7");
    // odd line with new scroll: buffer must keep line 100 content
    render(101, 77, 200, "R4");   scan(100, 250, 0, "R4");

    // blanking output
    @(negedge clk); active = 1'b0; hcount = 10'd37;
    @(negedge clk);
    chk(pix == 8'd0, "R9", "blank output", int'(pix), 0);

    for (int i = 0; i < 8; i++) begin
      int ln, sx, sy;
      ln = 2 * int'($urandom % 240);
      sx = int'($urandom % 512);
      sy = int'($urandom % 512);
      render(ln, sx, sy, "R6");
      scan(ln, sx, sy, "R3 R5 R6 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule